// File: doc/BRIEF.md
# Mode-Selectable 10/8-Bit Sample Compander

This block converts sample words between the 10-bit width of the converters and the 8-bit width of a transmission slot. It has one path for each direction. The transmit path reduces 10-bit two's complement samples to bytes. The receive path rebuilds 10-bit samples from bytes. Three channels share both paths. Channel codes 0 and 1 carry AC waveforms. A code with bit 1 set (2 or 3) carries the DC supply reading. Each direction has its own valid/ready pair on its input side and on its output side.

A mode input selects between two encodings. In companding mode, AC samples are coded as sign-magnitude with a segment and a mantissa, so small amplitudes keep full resolution and large amplitudes are coded more coarsely. In truncation mode, only the upper eight bits travel. The DC channel always uses the truncation form. The mode input is taken only on a frame-start pulse, so all samples in one frame use the same encoding.

Top module: `sample_compander`

## Requirements
- R1: After reset both output valids are 0, both input readies are 1, and the latched mode is truncation (0).
- R2: An accepted sample appears on the matching output one cycle later, together with its channel code. While an output is valid and its ready is low, the output holds steady and the input ready of that path is 0.
- R3: The mode (1 = companding, 0 = truncation) is latched on `frame_start` only. A transfer in the same cycle as `frame_start` uses the newly presented mode. Changes to `mode` between frame starts have no effect.
- R4: The compressed byte is {sign, segment[2:0], mantissa[3:0]}, with the sign in bit 7. The magnitude m is the sample for a sign of 0 and its bitwise inverse for a sign of 1, giving a range of 0..511. If m < 16, the segment is 0 and the mantissa is m. Otherwise the segment is s = 1..5, where 16·2^(s-1) ≤ m < 32·2^(s-1), and the mantissa is (m >> (s-1)) mod 16.
- R5: The compressor never emits segment codes 6 or 7.
- R6: The expander rebuilds the magnitude at the centre of the step. Segments 0 and 1 are exact. For a segment s ≥ 2 the magnitude is (16+mantissa)·2^(s-1) + 2^(s-2), so a compress/expand round trip is within half a step of the original.
- R7: In truncation mode the transmit byte is sample[9:2], and the received sample is {byte, 2'b00}.
- R8: Channel codes with bit 1 set always use the truncation form in both directions, whatever the mode.
- R9: The expander maps segment codes 6 and 7 to full-scale magnitude 511 (+511 for sign 0, -512 for sign 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | Requested encoding: 1 companding, 0 truncation |
| frame_start | input | 1 | Frame boundary pulse that latches `mode` |
| tx_in_valid | input | 1 | Transmit sample offered |
| tx_in_ready | output | 1 | Transmit path can take a sample |
| tx_in_chan | input | 2 | Channel code of transmit sample |
| tx_in_sample | input | 10 | 10-bit two's complement sample |
| tx_out_valid | output | 1 | Coded byte available |
| tx_out_ready | input | 1 | Consumer takes coded byte |
| tx_out_chan | output | 2 | Channel code of coded byte |
| tx_out_byte | output | 8 | Coded byte |
| rx_in_valid | input | 1 | Received byte offered |
| rx_in_ready | output | 1 | Receive path can take a byte |
| rx_in_chan | input | 2 | Channel code of received byte |
| rx_in_byte | input | 8 | Received byte |
| rx_out_valid | output | 1 | Rebuilt sample available |
| rx_out_ready | input | 1 | Consumer takes rebuilt sample |
| rx_out_chan | output | 2 | Channel code of rebuilt sample |
| rx_out_sample | output | 10 | Rebuilt 10-bit sample |

## Verification
Two functions can fall in the same cycle: a frame-start pulse that changes the mode, and a sample transfer. The bench provokes this by presenting a truncation request with `frame_start` in the same cycle as a sample whose two encodings differ. It then checks that the byte uses the new mode, and that a later mode change with no pulse is ignored. Full sweeps over all 1024 samples and all 256 bytes are compared against arithmetic models in both modes and on the DC channel.

// File: rtl/sample_compander.sv
module sample_compander (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic       frame_start,
  input  logic       tx_in_valid,
  output logic       tx_in_ready,
  input  logic [1:0] tx_in_chan,
  input  logic [9:0] tx_in_sample,
  output logic       tx_out_valid,
  input  logic       tx_out_ready,
  output logic [1:0] tx_out_chan,
  output logic [7:0] tx_out_byte,
  input  logic       rx_in_valid,
  output logic       rx_in_ready,
  input  logic [1:0] rx_in_chan,
  input  logic [7:0] rx_in_byte,
  output logic       rx_out_valid,
  input  logic       rx_out_ready,
  output logic [1:0] rx_out_chan,
  output logic [9:0] rx_out_sample
);

  function automatic logic [7:0] squeeze(input logic [9:0] s);
    logic [8:0] m;
    logic [8:0] sh;
    logic [2:0] seg;
    m = s[9] ? ~s[8:0] : s[8:0];
    if      (m[8]) seg = 3'd5;
    else if (m[7]) seg = 3'd4;
    else if (m[6]) seg = 3'd3;
    else if (m[5]) seg = 3'd2;
    else if (m[4]) seg = 3'd1;
    else           seg = 3'd0;
    sh = (seg == 3'd0) ? m : (m >> (seg - 3'd1));
    return {s[9], seg, sh[3:0]};
  endfunction

  function automatic logic [9:0] stretch(input logic [7:0] b);
    logic [2:0] seg;
    logic [8:0] m;
    seg = b[6:4];
    if (seg == 3'd0)      m = {5'd0, b[3:0]};
    else if (seg > 3'd5)  m = 9'h1FF;
    else begin
      m = {4'd0, 1'b1, b[3:0]} << (seg - 3'd1);
      if (seg >= 3'd2) m = m + (9'd1 << (seg - 3'd2));
    end
    return {b[7], b[7] ? ~m : m};
  endfunction

  logic mode_q;
  logic eff_mode;
  assign eff_mode = frame_start ? mode : mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           mode_q <= 1'b0;
    else if (frame_start) mode_q <= mode;
  end

  logic tx_take, tx_plain;
  assign tx_in_ready = !tx_out_valid || tx_out_ready;
  assign tx_take     = tx_in_valid && tx_in_ready;
  assign tx_plain    = tx_in_chan[1] || !eff_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_out_valid <= 1'b0;
      tx_out_chan  <= 2'd0;
      tx_out_byte  <= 8'd0;
    end else begin
      if (tx_take) begin
        tx_out_chan <= tx_in_chan;
        tx_out_byte <= tx_plain ? tx_in_sample[9:2] : squeeze(tx_in_sample);
      end
      if (tx_in_ready) tx_out_valid <= tx_in_valid;
    end
  end

  logic rx_take, rx_plain;
  assign rx_in_ready = !rx_out_valid || rx_out_ready;
  assign rx_take     = rx_in_valid && rx_in_ready;
  assign rx_plain    = rx_in_chan[1] || !eff_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_out_valid  <= 1'b0;
      rx_out_chan   <= 2'd0;
      rx_out_sample <= 10'd0;
    end else begin
      if (rx_take) begin
        rx_out_chan   <= rx_in_chan;
        rx_out_sample <= rx_plain ? {rx_in_byte, 2'b00} : stretch(rx_in_byte);
      end
      if (rx_in_ready) rx_out_valid <= rx_in_valid;
    end
  end

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_byte) && $stable(tx_out_chan));

  assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready |=> rx_out_valid && $stable(rx_out_sample) && $stable(rx_out_chan));

  assert_mode_frame_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_q));

  assert_dc_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take && tx_in_chan[1] |=> tx_out_byte == $past(tx_in_sample[9:2]));

  assert_seg_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take && !tx_in_chan[1] && eff_mode |=> tx_out_byte[6:4] <= 3'd5);

  assert_rx_plain_lsb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take && (rx_in_chan[1] || !eff_mode) |=> rx_out_sample[1:0] == 2'b00);

endmodule

// File: tb/sample_compander_bench.sv
module sample_compander_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, frame_start = 1'b0;
  logic tx_in_valid = 1'b0, tx_out_ready = 1'b1;
  logic [1:0] tx_in_chan = 2'd0;
  logic [9:0] tx_in_sample = 10'd0;
  logic rx_in_valid = 1'b0, rx_out_ready = 1'b1;
  logic [1:0] rx_in_chan = 2'd0;
  logic [7:0] rx_in_byte = 8'd0;
  logic tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [1:0] tx_out_chan, rx_out_chan;
  logic [7:0] tx_out_byte;
  logic [9:0] rx_out_sample;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sample_compander u_sample_compander (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int enc_ref(input int s);
    int m, seg, man;
    m = (s < 0) ? -s - 1 : s;
    seg = 0; man = m;
    for (int k = 1; k <= 5; k++)
      if (m >= 16 * (1 << (k - 1))) begin
        seg = k;
        man = (m - 16 * (1 << (k - 1))) / (1 << (k - 1));
      end
    return ((s < 0) ? 128 : 0) + seg * 16 + man;
  endfunction

  function automatic int dec_ref(input int b);
    int seg, man, m, step;
    seg = (b / 16) % 8; man = b % 16;
    step = (seg <= 1) ? 1 : (1 << (seg - 1));
    if (seg == 0)      m = man;
    else if (seg > 5)  m = 511;
    else               m = 16 * step + man * step + ((seg >= 2) ? step / 2 : 0);
    return (b >= 128) ? -m - 1 : m;
  endfunction

  task automatic tx_xfer(input bit fs, input logic [1:0] ch, input int s,
                         output int b, output int och, output bit v);
    @(negedge clk);
    frame_start = fs; tx_in_valid = 1'b1; tx_in_chan = ch; tx_in_sample = 10'(s);
    @(negedge clk);
    frame_start = 1'b0; tx_in_valid = 1'b0;
    b = int'(tx_out_byte); och = int'(tx_out_chan); v = tx_out_valid;
  endtask

  task automatic rx_xfer(input logic [1:0] ch, input int b,
                         output int s, output int och, output bit v);
    @(negedge clk);
    rx_in_valid = 1'b1; rx_in_chan = ch; rx_in_byte = 8'(b);
    @(negedge clk);
    rx_in_valid = 1'b0;
    s = int'($signed(rx_out_sample)); och = int'(rx_out_chan); v = rx_out_valid;
  endtask

  task automatic set_mode(input bit md);
    @(negedge clk); mode = md; frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  initial begin
    int b, s, och, b2;
    bit v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_out_valid == 0, "R1 tx_out_valid", tx_out_valid, 0);
    check(rx_out_valid == 0, "R1 rx_out_valid", rx_out_valid, 0);
    check(tx_in_ready == 1, "R1 tx_in_ready", tx_in_ready, 1);
    check(rx_in_ready == 1, "R1 rx_in_ready", rx_in_ready, 1);
    tx_xfer(0, 2'd0, 5, b, och, v);
    check(b == 1, "R1 reset mode truncation", b, 1);

    set_mode(1'b1);
    for (int x = -512; x < 512; x++) begin
      int seg, step, diff;
      tx_xfer(0, 2'(x & 1), x, b, och, v);
      check(v, "R2 tx valid", v, 1);
      check(och == (x & 1), "R2 tx chan", och, x & 1);
      check(b == enc_ref(x), "R4 compress", b, enc_ref(x));
      seg = (b / 16) % 8;
      check(seg <= 5, "R5 segment range", seg, 5);
      rx_xfer(2'd0, b, s, och, v);
      step = (seg <= 1) ? 1 : (1 << (seg - 1));
      diff = (s > x) ? s - x : x - s;
      check(diff <= step / 2, "R6 round trip", s, x);
    end
    for (int y = 0; y < 256; y++) begin
      rx_xfer(2'd1, y, s, och, v);
      check(v && och == 1, "R2 rx valid/chan", och, 1);
      if ((y / 16) % 8 > 5) check(s == dec_ref(y), "R9 saturate", s, dec_ref(y));
      else                  check(s == dec_ref(y), "R6 expand", s, dec_ref(y));
      rx_xfer(2'd2, y, s, och, v);
      check(s == ((y >= 128 ? y - 256 : y) * 4), "R8 dc rx plain", s, (y >= 128 ? y - 256 : y) * 4);
    end
    for (int x = -512; x < 512; x++) begin
      tx_xfer(0, 2'(2 + (x & 1)), x, b, och, v);
      check(b == ((x >>> 2) & 255), "R8 dc tx plain", b, (x >>> 2) & 255);
    end

    @(negedge clk); mode = 1'b0;
    tx_xfer(1, 2'd0, 5, b, och, v);
    check(b == 1, "R3 same-cycle frame start", b, 1);
    @(negedge clk); mode = 1'b1;
    tx_xfer(0, 2'd0, 5, b, och, v);
    check(b == 1, "R3 mode ignored mid-frame", b, 1);
    rx_xfer(2'd0, 8'h35, s, och, v);
    check(s == 212, "R3 rx mode ignored mid-frame", s, 212);
    tx_xfer(1, 2'd0, 5, b, och, v);
    check(b == 5, "R3 frame start to compand", b, 5);
    set_mode(1'b0);

    for (int x = -512; x < 512; x++) begin
      tx_xfer(0, 2'd1, x, b, och, v);
      check(b == ((x >>> 2) & 255), "R7 truncate tx", b, (x >>> 2) & 255);
    end
    for (int y = 0; y < 256; y++) begin
      rx_xfer(2'd0, y, s, och, v);
      check(s == ((y >= 128 ? y - 256 : y) * 4), "R7 truncate rx", s, (y >= 128 ? y - 256 : y) * 4);
    end

    @(negedge clk);
    tx_out_ready = 1'b0; tx_in_valid = 1'b1; tx_in_chan = 2'd1; tx_in_sample = 10'd400;
    @(negedge clk);
    tx_in_sample = 10'd8;
    check(tx_out_valid && tx_out_byte == 100, "R2 stall first", tx_out_byte, 100);
    check(tx_in_ready == 0, "R2 stall ready low", tx_in_ready, 0);
    @(negedge clk);
    b2 = int'(tx_out_byte);
    check(tx_out_valid && b2 == 100, "R2 stall hold", b2, 100);
    tx_out_ready = 1'b1;
    @(negedge clk);
    tx_in_valid = 1'b0;
    check(tx_out_valid && tx_out_byte == 2, "R2 after stall", tx_out_byte, 2);
    @(negedge clk);
    check(tx_out_valid == 0, "R2 drained", tx_out_valid, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule